// File: doc/BRIEF.md
# Linked Breakpoint Match Unit

A bank of hardware breakpoint comparators that watches the instruction stream as it retires. Every breakpoint owns a control word and a 64-bit value word, both loaded through a simple write port. On each cycle in which an observed instruction is presented, every enabled breakpoint compares the instruction's address, context ID and virtual machine ID against its value word according to its programmed type, and a per-breakpoint event bit is raised one cycle later.

A breakpoint can check an address (equal or not equal), a context ID, a VMID, or a VMID together with a context ID. An address breakpoint with its link bit set also depends on a second, context-matching breakpoint picked by a 4-bit index, and fires only when both conditions hold in the same cycle. A context breakpoint with its link bit set raises nothing itself and serves only as such a qualifier. Only the highest-numbered `NUM_CTX` breakpoints are context-aware; the others read every type as an address type.

Top module: `bp_match_unit`

## Requirements
- R1: After reset every breakpoint is disabled, every value word is zero and `bp_event` is all zero; an observation right after reset raises no event.
- R2: `bp_event` is registered: it reflects an observation in the cycle after `obs_valid` is high, and is all zero in the cycle after `obs_valid` is low.
- R3: A write with `cfg_sel_ctrl`=1 loads the control word of breakpoint `cfg_idx`: bit 0 is the enable, bits 23:20 the type, bits 19:16 the link index, all other bits are ignored. With `cfg_sel_ctrl`=0 the whole 64-bit value word is loaded. A write takes effect from the next cycle; an observation in the same cycle uses the old settings.
- R4: Type 0000 (address equal) fires when `obs_addr` equals the value word.
- R5: Breakpoints 0 to `NUM_BP-NUM_CTX-1` are not context-aware: type bits 3:1 are read as zero, so e.g. 0010 or 0100 acts as 0000.
- R6: Type 0100 (address not equal) fires when `obs_addr` differs from the value word, but acts exactly as type 0000 when `regime64` is high, or when `halt_en` and `halt_ok` are both high.
- R7: Type 0010 fires when `obs_ctxid` equals value bits 31:0.
- R8: Type 1000 fires when `obs_vmid` equals value bits 39:32.
- R9: Type 1010 fires only when both value bits 31:0 equal `obs_ctxid` and value bits 39:32 equal `obs_vmid`.
- R10: Linked address types 0001 and 0101 fire only when their own address condition holds and the breakpoint selected by bits 19:16 is enabled, has a context type (0010, 0011, 1000, 1001, 1010, 1011) and its context condition holds in the same cycle; a link index that selects an address breakpoint or no breakpoint never fires.
- R11: Linked context types 0011, 1001 and 1011 never raise their own event.
- R12: Reserved types (any value not listed above) never raise an event and never qualify a linked breakpoint.
- R13: A breakpoint whose enable bit is zero raises no event and qualifies no linked breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe of the configuration port |
| cfg_sel_ctrl | input | 1 | 1 selects the control word, 0 the value word |
| cfg_idx | input | IDX_W (3) | Breakpoint index being written |
| cfg_wdata | input | 64 | Write data |
| obs_valid | input | 1 | An instruction is being observed this cycle |
| obs_addr | input | ADDR_W (64) | Address of the observed instruction |
| obs_ctxid | input | 32 | Current context ID |
| obs_vmid | input | 8 | Current VMID |
| regime64 | input | 1 | 64-bit regime; forces not-equal types to equal |
| halt_en | input | 1 | Halting debug enabled |
| halt_ok | input | 1 | Halting allowed |
| bp_event | output | NUM_BP (6) | Registered per-breakpoint event |

## Verification
Two functions can coincide in one cycle: a configuration write to a breakpoint and an observation that the same breakpoint judges, and a linked address breakpoint firing together with the context breakpoint that qualifies it. The first is provoked by disabling a matching breakpoint in the very cycle that presents its address, where the old setting must still fire and the next observation must not. The second is provoked by giving the qualifier an unlinked context type so both bits rise together, then switching it to a linked type where only the address bit may rise; a behavioural model of the bank, updated on every clock, judges both along with a long run of mixed random writes and observations.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int VAL_W        = 64;
    localparam int CTXID_W      = 32;
    localparam int VMID_W       = 8;
    localparam int VMID_LSB     = 32;
    localparam int TYPE_W       = 4;
    localparam int LBN_W        = 4;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_LBN_LSB  = 16;
    localparam int CTL_TYPE_LSB = 20;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_ADDR,
        KIND_MISM,
        KIND_CTX,
        KIND_VMID,
        KIND_VMCTX
    } bp_kind_e;

    typedef struct packed {
        logic              en;
        logic [TYPE_W-1:0] btype;
        logic [LBN_W-1:0]  lbn;
    } bp_ctrl_t;

    typedef struct packed {
        bp_kind_e kind;
        logic     linked;
    } bp_dec_t;

    // Base kind from type bits 3:1, link enable from bit 0.
    function automatic bp_dec_t decode_type(input logic [TYPE_W-1:0] t, input logic aware);
        bp_dec_t           d;
        logic [TYPE_W-1:0] e;
        e = aware ? t : {{(TYPE_W-1){1'b0}}, t[0]};
        d.linked = e[0];
        case (e[TYPE_W-1:1])
            3'b000:  d.kind = KIND_ADDR;
            3'b001:  d.kind = KIND_CTX;
            3'b010:  d.kind = KIND_MISM;
            3'b100:  d.kind = KIND_VMID;
            3'b101:  d.kind = KIND_VMCTX;
            default: d.kind = KIND_NONE;
        endcase
        return d;
    endfunction

    function automatic logic is_ctx_kind(input bp_kind_e k);
        return (k == KIND_CTX) || (k == KIND_VMID) || (k == KIND_VMCTX);
    endfunction

endpackage

// File: rtl/bp_regs.sv
module bp_regs
    import bpm_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int IDX_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic                         cfg_sel_ctrl,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [VAL_W-1:0]             cfg_wdata,
    output bp_ctrl_t [NUM_BP-1:0]        ctrl_o,
    output logic [NUM_BP-1:0][VAL_W-1:0] val_o
);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
        logic hit;
        assign hit = cfg_we && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_o[g] <= '0;
                val_o[g]  <= '0;
            end else if (hit) begin
                if (cfg_sel_ctrl) begin
                    ctrl_o[g].en    <= cfg_wdata[CTL_EN_BIT];
                    ctrl_o[g].btype <= cfg_wdata[CTL_TYPE_LSB +: TYPE_W];
                    ctrl_o[g].lbn   <= cfg_wdata[CTL_LBN_LSB +: LBN_W];
                end else begin
                    val_o[g] <= cfg_wdata;
                end
            end
        end
    end

endmodule

// File: rtl/bp_cond.sv
module bp_cond
    import bpm_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 64
) (
    input  logic [NUM_BP-1:0]             en,
    input  logic [NUM_BP-1:0][TYPE_W-1:0] btype,
    input  logic [NUM_BP-1:0][VAL_W-1:0]  val,
    input  logic [ADDR_W-1:0]             obs_addr,
    input  logic [CTXID_W-1:0]            obs_ctxid,
    input  logic [VMID_W-1:0]             obs_vmid,
    input  logic                          regime64,
    input  logic                          halt_en,
    input  logic                          halt_ok,
    output bp_dec_t [NUM_BP-1:0]          dec_o,
    output logic [NUM_BP-1:0]             own_hit_o,
    output logic [NUM_BP-1:0]             qual_o
);

    localparam int FIRST_AWARE = NUM_BP - NUM_CTX;

    logic force_equal;
    assign force_equal = regime64 || (halt_en && halt_ok);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        localparam logic AWARE = (g >= FIRST_AWARE);
        logic addr_eq, cid_eq, vm_eq;

        assign dec_o[g] = decode_type(btype[g], AWARE);
        assign addr_eq  = (val[g][ADDR_W-1:0] == obs_addr);
        assign cid_eq   = (val[g][CTXID_W-1:0] == obs_ctxid);
        assign vm_eq    = (val[g][VMID_LSB +: VMID_W] == obs_vmid);

        always_comb begin
            case (dec_o[g].kind)
                KIND_ADDR:  own_hit_o[g] = addr_eq;
                KIND_MISM:  own_hit_o[g] = force_equal ? addr_eq : !addr_eq;
                KIND_CTX:   own_hit_o[g] = cid_eq;
                KIND_VMID:  own_hit_o[g] = vm_eq;
                KIND_VMCTX: own_hit_o[g] = cid_eq && vm_eq;
                default:    own_hit_o[g] = 1'b0;
            endcase
        end

        assign qual_o[g] = en[g] && is_ctx_kind(dec_o[g].kind) && own_hit_o[g];
    end

endmodule

// File: rtl/bp_link.sv
module bp_link
    import bpm_pkg::*;
#(
    parameter int NUM_BP = 6
) (
    input  logic [NUM_BP-1:0]            en,
    input  logic [NUM_BP-1:0][LBN_W-1:0] lbn,
    input  bp_dec_t [NUM_BP-1:0]         dec,
    input  logic [NUM_BP-1:0]            own_hit,
    input  logic [NUM_BP-1:0]            qual,
    output logic [NUM_BP-1:0]            fire_o
);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_link
        logic sel_qual;
        logic cond;

        // Index-selected qualifier; an index beyond the bank selects nothing.
        always_comb begin
            sel_qual = 1'b0;
            for (int j = 0; j < NUM_BP; j++) begin
                if (lbn[g] == LBN_W'(j)) sel_qual = qual[j];
            end
        end

        always_comb begin
            case (dec[g].kind)
                KIND_ADDR, KIND_MISM:
                    cond = dec[g].linked ? (own_hit[g] && sel_qual) : own_hit[g];
                KIND_CTX, KIND_VMID, KIND_VMCTX:
                    cond = !dec[g].linked && own_hit[g];
                default:
                    cond = 1'b0;
            endcase
        end

        assign fire_o[g] = en[g] && cond;
    end

endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bpm_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 64,
    localparam int IDX_W  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel_ctrl,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [VAL_W-1:0]   cfg_wdata,
    input  logic               obs_valid,
    input  logic [ADDR_W-1:0]  obs_addr,
    input  logic [CTXID_W-1:0] obs_ctxid,
    input  logic [VMID_W-1:0]  obs_vmid,
    input  logic               regime64,
    input  logic               halt_en,
    input  logic               halt_ok,
    output logic [NUM_BP-1:0]  bp_event
);

    bp_ctrl_t [NUM_BP-1:0]             ctrl_q;
    logic [NUM_BP-1:0][VAL_W-1:0]      val_q;
    logic [NUM_BP-1:0]                 en_w;
    logic [NUM_BP-1:0][TYPE_W-1:0]     btype_w;
    logic [NUM_BP-1:0][LBN_W-1:0]      lbn_w;
    bp_dec_t [NUM_BP-1:0]              dec_w;
    logic [NUM_BP-1:0]                 own_hit_w;
    logic [NUM_BP-1:0]                 qual_w;
    logic [NUM_BP-1:0]                 fire_w;

    bp_regs #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_sel_ctrl (cfg_sel_ctrl),
        .cfg_idx      (cfg_idx),
        .cfg_wdata    (cfg_wdata),
        .ctrl_o       (ctrl_q),
        .val_o        (val_q)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_split
        assign en_w[g]    = ctrl_q[g].en;
        assign btype_w[g] = ctrl_q[g].btype;
        assign lbn_w[g]   = ctrl_q[g].lbn;
    end

    bp_cond #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_cond (
        .en        (en_w),
        .btype     (btype_w),
        .val       (val_q),
        .obs_addr  (obs_addr),
        .obs_ctxid (obs_ctxid),
        .obs_vmid  (obs_vmid),
        .regime64  (regime64),
        .halt_en   (halt_en),
        .halt_ok   (halt_ok),
        .dec_o     (dec_w),
        .own_hit_o (own_hit_w),
        .qual_o    (qual_w)
    );

    bp_link #(.NUM_BP(NUM_BP)) u_link (
        .en      (en_w),
        .lbn     (lbn_w),
        .dec     (dec_w),
        .own_hit (own_hit_w),
        .qual    (qual_w),
        .fire_o  (fire_w)
    );

    always_ff @(posedge clk) begin
        if (rst) bp_event <= '0;
        else     bp_event <= obs_valid ? fire_w : '0;
    end

endmodule

// File: rtl/bp_match_chk.sv
module bp_match_chk
    import bpm_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int ADDR_W = 64
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         obs_valid,
    input logic [ADDR_W-1:0]            obs_addr,
    input logic                         regime64,
    input logic                         halt_en,
    input logic                         halt_ok,
    input logic [NUM_BP-1:0]            en,
    input bp_dec_t [NUM_BP-1:0]         dec,
    input logic [NUM_BP-1:0][VAL_W-1:0] val,
    input logic [NUM_BP-1:0]            bp_event
);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !obs_valid |=> (bp_event == '0));

    for (genvar g = 0; g < NUM_BP; g++) begin : g_chk
        assert_disabled_silent_R13: assert property (@(posedge clk) disable iff (rst)
            !en[g] |=> !bp_event[g]);

        assert_reserved_silent_R12: assert property (@(posedge clk) disable iff (rst)
            (dec[g].kind == KIND_NONE) |=> !bp_event[g]);

        assert_linked_ctx_silent_R11: assert property (@(posedge clk) disable iff (rst)
            (is_ctx_kind(dec[g].kind) && dec[g].linked) |=> !bp_event[g]);

        assert_mism_fallback_R6: assert property (@(posedge clk) disable iff (rst)
            (obs_valid && en[g] && dec[g].kind == KIND_MISM && !dec[g].linked &&
             (regime64 || (halt_en && halt_ok)) && (val[g][ADDR_W-1:0] != obs_addr))
            |=> !bp_event[g]);
    end

endmodule

bind bp_match_unit bp_match_chk #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .obs_valid (obs_valid),
    .obs_addr  (obs_addr),
    .regime64  (regime64),
    .halt_en   (halt_en),
    .halt_ok   (halt_ok),
    .en        (en_w),
    .dec       (dec_w),
    .val       (val_q),
    .bp_event  (bp_event)
);

// File: tb/tb_bp_match_unit.sv
module tb_bp_match_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NUM  = 6;
    localparam int NCTX = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel_ctrl = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic        obs_valid = 1'b0;
    logic [63:0] obs_addr = '0;
    logic [31:0] obs_ctxid = '0;
    logic [7:0]  obs_vmid = '0;
    logic        regime64 = 1'b0;
    logic        halt_en = 1'b0;
    logic        halt_ok = 1'b0;
    logic [NUM-1:0] bp_event;

    bp_match_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel_ctrl(cfg_sel_ctrl),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .obs_valid(obs_valid),
        .obs_addr(obs_addr), .obs_ctxid(obs_ctxid), .obs_vmid(obs_vmid),
        .regime64(regime64), .halt_en(halt_en), .halt_ok(halt_ok),
        .bp_event(bp_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic        m_en   [NUM];
    logic [3:0]  m_type [NUM];
    logic [3:0]  m_lbn  [NUM];
    logic [63:0] m_val  [NUM];
    logic [NUM-1:0] exp_ev;

    int    checks = 0;
    int    fails  = 0;
    bit    checking = 0;
    bit    done = 0;
    string cur_req = "R1";

    function automatic int eff_type(input int i);
        int t = int'(m_type[i]);
        if (i < NUM - NCTX) t = t % 2;
        return t;
    endfunction

    function automatic bit ctx_holds(input int j);
        int  t;
        bit  c_ok, v_ok;
        if (j >= NUM || !m_en[j]) return 0;
        t = eff_type(j);
        c_ok = (m_val[j][31:0] == obs_ctxid);
        v_ok = (m_val[j][39:32] == obs_vmid);
        if (t == 2 || t == 3)   return c_ok;
        if (t == 8 || t == 9)   return v_ok;
        if (t == 10 || t == 11) return c_ok && v_ok;
        return 0;
    endfunction

    function automatic logic [NUM-1:0] ref_events();
        logic [NUM-1:0] r = '0;
        for (int i = 0; i < NUM; i++) begin
            int t;
            bit same, a;
            t = eff_type(i);
            same = (m_val[i] == obs_addr);
            if (!m_en[i]) continue;
            if (t == 0 || t == 1 || t == 4 || t == 5) begin
                if (t >= 4 && !(regime64 || (halt_en && halt_ok))) a = !same;
                else a = same;
                if (t % 2 == 1) r[i] = a && ctx_holds(int'(m_lbn[i]));
                else            r[i] = a;
            end else if (t == 2 || t == 8 || t == 10) begin
                r[i] = ctx_holds(i);
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_ev <= '0;
            for (int i = 0; i < NUM; i++) begin
                m_en[i] <= 1'b0; m_type[i] <= '0; m_lbn[i] <= '0; m_val[i] <= '0;
            end
        end else begin
            exp_ev <= obs_valid ? ref_events() : '0;
            if (cfg_we && int'(cfg_idx) < NUM) begin
                if (cfg_sel_ctrl) begin
                    m_en[cfg_idx]   <= cfg_wdata[0];
                    m_type[cfg_idx] <= cfg_wdata[23:20];
                    m_lbn[cfg_idx]  <= cfg_wdata[19:16];
                end else begin
                    m_val[cfg_idx] <= cfg_wdata;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            checks++;
            if (bp_event !== exp_ev) begin
                fails++;
                $display("FAIL %s: bp_event=%b expected %b at %0t", cur_req, bp_event, exp_ev, $time);
            end
        end
    end

    task automatic wr_ctrl(input int idx, input bit en, input logic [3:0] t, input logic [3:0] l);
        cfg_we = 1; cfg_sel_ctrl = 1; cfg_idx = 3'(idx);
        // reserved bits set to show they are ignored (R3)
        cfg_wdata = 64'hA5A5_0000_FF00_3E00 | (64'(t) << 20) | (64'(l) << 16) | 64'(en);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wr_val(input int idx, input logic [63:0] v);
        cfg_we = 1; cfg_sel_ctrl = 0; cfg_idx = 3'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic obs(input logic [63:0] a, input logic [31:0] c, input logic [7:0] v);
        obs_valid = 1; obs_addr = a; obs_ctxid = c; obs_vmid = v;
        @(negedge clk);
        obs_valid = 0;
    endtask

    localparam logic [63:0] CV = {24'h0, 8'h5A, 32'hABCD_0123};

    logic [63:0] pool_v [4];

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        checking = 1;

        cur_req = "R1";
        obs(64'h0, 32'h0, 8'h0);
        @(negedge clk);

        cur_req = "R4";
        wr_val(1, 64'h1000);
        wr_ctrl(1, 1, 4'b0000, 0);
        obs(64'h1000, 0, 0);
        obs(64'h1004, 0, 0);
        obs(64'h1000, 0, 0);

        cur_req = "R2";
        obs_valid = 0; obs_addr = 64'h1000;
        @(negedge clk);
        @(negedge clk);

        cur_req = "R3";
        cfg_we = 1; cfg_sel_ctrl = 1; cfg_idx = 1; cfg_wdata = 64'h0000_0000_0000_0000;
        obs_valid = 1; obs_addr = 64'h1000;
        @(negedge clk);
        cfg_we = 0; obs_valid = 0;
        obs(64'h1000, 0, 0);
        wr_ctrl(1, 1, 4'b0000, 0);
        cfg_we = 1; cfg_sel_ctrl = 0; cfg_idx = 1; cfg_wdata = 64'h1100;
        obs_valid = 1; obs_addr = 64'h1000;
        @(negedge clk);
        cfg_we = 0; obs_valid = 0;
        obs(64'h1000, 0, 0);
        obs(64'h1100, 0, 0);
        wr_ctrl(1, 0, 4'b0000, 0);

        cur_req = "R5";
        wr_val(0, 64'h2000);
        wr_ctrl(0, 1, 4'b0010, 0);
        obs(64'h2000, 32'h0, 0);
        obs(64'h2004, 32'h2000, 0);
        wr_ctrl(0, 1, 4'b0100, 0);
        obs(64'h2008, 0, 0);
        obs(64'h2000, 0, 0);
        wr_ctrl(0, 0, 4'b0000, 0);

        cur_req = "R6";
        wr_val(4, 64'h3000);
        wr_ctrl(4, 1, 4'b0100, 0);
        obs(64'h3000, 0, 0);
        obs(64'h3008, 0, 0);
        regime64 = 1;
        obs(64'h3008, 0, 0);
        obs(64'h3000, 0, 0);
        regime64 = 0; halt_en = 1;
        obs(64'h3000, 0, 0);
        halt_ok = 1;
        obs(64'h3000, 0, 0);
        obs(64'h3008, 0, 0);
        halt_en = 0;
        obs(64'h3008, 0, 0);
        halt_ok = 0;
        wr_ctrl(4, 0, 4'b0000, 0);

        cur_req = "R7";
        wr_val(5, CV);
        wr_ctrl(5, 1, 4'b0010, 0);
        obs(64'h9, 32'hABCD_0123, 8'h00);
        obs(64'h9, 32'hABCD_0124, 8'h5A);

        cur_req = "R8";
        wr_ctrl(5, 1, 4'b1000, 0);
        obs(64'h9, 32'h0, 8'h5A);
        obs(64'h9, 32'hABCD_0123, 8'h5B);

        cur_req = "R9";
        wr_ctrl(5, 1, 4'b1010, 0);
        obs(64'h9, 32'hABCD_0123, 8'h5A);
        obs(64'h9, 32'hABCD_0123, 8'h00);
        obs(64'h9, 32'h0, 8'h5A);

        cur_req = "R10";
        wr_val(2, 64'h4000);
        wr_ctrl(2, 1, 4'b0001, 5);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        obs(64'h4000, 32'hABCD_0000, 8'h5A);
        obs(64'h4004, 32'hABCD_0123, 8'h5A);
        wr_ctrl(5, 1, 4'b1011, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_val(3, 64'h4000);
        wr_ctrl(3, 1, 4'b0000, 0);
        wr_ctrl(2, 1, 4'b0001, 3);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_ctrl(2, 1, 4'b0001, 9);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_ctrl(3, 0, 4'b0000, 0);
        wr_ctrl(2, 1, 4'b0001, 5);
        wr_val(4, 64'h5000);
        wr_ctrl(4, 1, 4'b0101, 5);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        obs(64'h5000, 32'hABCD_0123, 8'h5A);
        wr_ctrl(4, 0, 4'b0000, 0);

        cur_req = "R11";
        wr_ctrl(5, 1, 4'b0011, 0);
        obs(64'h9, 32'hABCD_0123, 8'h5A);
        wr_ctrl(5, 1, 4'b1001, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);

        cur_req = "R12";
        wr_ctrl(5, 1, 4'b0110, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_ctrl(5, 1, 4'b1111, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_val(5, 64'h4000);
        wr_ctrl(5, 1, 4'b1100, 0);
        obs(64'h4000, 32'h0000_4000, 8'h00);

        cur_req = "R13";
        wr_val(5, CV);
        wr_ctrl(5, 0, 4'b1010, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);
        wr_ctrl(2, 0, 4'b0000, 0);
        obs(64'h4000, 32'hABCD_0123, 8'h5A);

        cur_req = "R10 mixed";
        pool_v[0] = CV;
        pool_v[1] = 64'h0000_0011_0000_0001;
        pool_v[2] = 64'h0000_0022_0000_4000;
        pool_v[3] = 64'h0000_005A_0000_0001;
        for (int n = 0; n < 3000; n++) begin
            cfg_we = ($urandom % 3) == 0;
            cfg_sel_ctrl = $urandom % 2;
            cfg_idx = 3'($urandom % 7);
            if (cfg_sel_ctrl)
                cfg_wdata = (64'($urandom % 16) << 20) | (64'($urandom % 8) << 16) |
                            64'(($urandom % 4) != 0);
            else
                cfg_wdata = pool_v[$urandom % 4];
            obs_valid = ($urandom % 4) != 0;
            obs_addr  = pool_v[$urandom % 4];
            obs_ctxid = pool_v[$urandom % 4][31:0];
            obs_vmid  = pool_v[$urandom % 4][39:32];
            regime64  = ($urandom % 4) == 0;
            halt_en   = $urandom % 2;
            halt_ok   = $urandom % 2;
            @(negedge clk);
        end
        cfg_we = 0; obs_valid = 0;
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule